// File: doc/BRIEF.md
# Port-Based VLAN Egress Filter

This block keeps the per-port VLAN settings of a seven-port switch and answers one question per request: for a frame that arrived on a given port, to which ports may it be sent, and which filtering database should the address lookup use. Each port owns three configuration words. The map word holds an egress mask and a database identifier (FID). The VID word holds the port's default VLAN ID. The control word holds a two-bit port state. A plain register write/read port gives access to these words. Frame parsing and tag handling sit outside the block.

Lookups use a valid/ready stream. A request carries an ingress port number. It is accepted on any rising edge where `lkp_valid` and `lkp_ready` are both high. The matching response appears on the next edge, and it stays stable until it is taken with `egr_ready`. `lkp_ready` is high while the response slot is empty, or while the pending response is being taken in the same cycle. A single response register therefore sustains one lookup per cycle when the consumer is always ready. When the consumer stalls, it holds off new requests.

Top module: `vlan_egress_filter`

## Requirements
- R1: After reset, ports 0, 1, 2, 3 and 6 form one group with FID 1, and ports 4 and 5 form a second group with FID 2. Each port's egress mask holds the other members of its group. Port p has default VID p+1, and every port is in the forwarding state (3).
- R2: Configuration address bits [4:2] select the port, and bits [1:0] select the word: 0 is the map word, 1 is the VID word, 2 is the control word, 3 is unused. In the map word, bits [6:0] are the egress mask and bits [15:12] are the FID. Bits [11:7] always read zero and ignore writes.
- R3: Every write to a port's map word clears that port's own bit in the stored mask, whatever value was written.
- R4: The VID word stores bits [11:0] as the default VID. Bits [15:12] read zero.
- R5: The control word stores a state in bits [1:0], and bits [15:2] read zero. Only state 3 counts as forwarding. States 0 (disabled), 1 and 2 do not forward.
- R6: A response carries the ingress port's mask ANDed with the set of forwarding ports, together with the ingress port's FID. The mask is empty when the ingress port itself is not forwarding.
- R7: A request accepted on one edge gives `egr_valid` high after that edge, with the same port echoed on `egr_port`. The latency is one cycle, and `lkp_ready` is high after reset.
- R8: While `egr_valid` is high and `egr_ready` is low, the response stays unchanged and `lkp_ready` is low.
- R9: An ingress port of 7 gives an empty mask and FID 0. Writes addressed to port 7 or to word 3 change nothing, and reads from those addresses return zero.
- R10: A lookup accepted on the same edge as a configuration write reports the settings that were in place before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the configuration word at `cfg_addr` |
| cfg_addr | input | 5 | Port number in [4:2], word select in [1:0] |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Combinational read of the word at `cfg_addr` |
| lkp_valid | input | 1 | Lookup request valid |
| lkp_ready | output | 1 | Lookup request can be accepted |
| lkp_port | input | 3 | Ingress port number of the request |
| egr_valid | output | 1 | Response valid |
| egr_ready | input | 1 | Consumer takes the response |
| egr_port | output | 3 | Ingress port echoed from the request |
| egr_mask | output | 7 | Permitted egress ports |
| egr_fid | output | 4 | FID for the address lookup |

## Verification
A configuration write and a lookup can land on the same clock edge. The lookup must then capture the mask, FID and port states from before the write. The bench provokes this by writing a new map word for port 0 while a lookup for port 0 is accepted on that same edge. It judges the result in two steps: the first response must still show the reset mask and FID, and a second lookup one cycle later must show the new values. A second collision the bench drives is the release of a stalled response in the same cycle as a new request. Here the bench checks that the held response stayed stable through the stall, and that the following response belongs to the new request.

// File: rtl/vlan_egress_pkg.sv
package vlan_egress_pkg;

  typedef enum logic [1:0] {
    SEL_MAP  = 2'd0,
    SEL_VID  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } vef_sel_e;

  localparam int          STATE_W  = 2;
  localparam int          SEL_W    = 2;
  localparam logic [1:0]  ST_FWD   = 2'd3;
  localparam logic [1:0]  ST_OFF   = 2'd0;

endpackage

// File: rtl/vlan_cfg_regs.sv
module vlan_cfg_regs
  import vlan_egress_pkg::*;
#(
  parameter int NUM_PORTS = 7,
  parameter int FID_W     = 4,
  parameter int VID_W     = 12,
  parameter int DATA_W    = 16,
  parameter int PORT_W    = 3,
  parameter logic [NUM_PORTS-1:0] GROUP_A = 7'h4F,
  parameter logic [FID_W-1:0]     FID_A   = 4'd1,
  parameter logic [FID_W-1:0]     FID_B   = 4'd2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [PORT_W-1:0]                   wr_port,
  input  vef_sel_e                            wr_sel,
  input  logic [DATA_W-1:0]                   wr_data,
  output logic [NUM_PORTS-1:0][NUM_PORTS-1:0] mask_q,
  output logic [NUM_PORTS-1:0][FID_W-1:0]     fid_q,
  output logic [NUM_PORTS-1:0][VID_W-1:0]     vid_q,
  output logic [NUM_PORTS-1:0][STATE_W-1:0]   state_q
);

  localparam int FID_LSB = DATA_W - FID_W;

  function automatic logic [NUM_PORTS-1:0] reset_mask(input int p);
    logic [NUM_PORTS-1:0] grp;
    grp = GROUP_A[p] ? GROUP_A : ~GROUP_A;
    grp[p] = 1'b0;
    return grp;
  endfunction

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic hit;
    logic [NUM_PORTS-1:0] own;
    assign hit = wr_en && (wr_port == PORT_W'(p));
    assign own = NUM_PORTS'(1) << p;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[p]  <= reset_mask(p);
        fid_q[p]   <= GROUP_A[p] ? FID_A : FID_B;
        vid_q[p]   <= VID_W'(p + 1);
        state_q[p] <= ST_FWD;
      end else if (hit) begin
        case (wr_sel)
          SEL_MAP: begin
            mask_q[p] <= wr_data[NUM_PORTS-1:0] & ~own;
            fid_q[p]  <= wr_data[FID_LSB +: FID_W];
          end
          SEL_VID:  vid_q[p]   <= wr_data[VID_W-1:0];
          SEL_CTRL: state_q[p] <= wr_data[STATE_W-1:0];
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/vlan_cfg_readmux.sv
module vlan_cfg_readmux
  import vlan_egress_pkg::*;
#(
  parameter int NUM_PORTS = 7,
  parameter int FID_W     = 4,
  parameter int VID_W     = 12,
  parameter int DATA_W    = 16,
  parameter int PORT_W    = 3
) (
  input  logic [PORT_W-1:0]                   rd_port,
  input  vef_sel_e                            rd_sel,
  input  logic [NUM_PORTS-1:0][NUM_PORTS-1:0] mask_q,
  input  logic [NUM_PORTS-1:0][FID_W-1:0]     fid_q,
  input  logic [NUM_PORTS-1:0][VID_W-1:0]     vid_q,
  input  logic [NUM_PORTS-1:0][STATE_W-1:0]   state_q,
  output logic [DATA_W-1:0]                   rd_data
);

  localparam int FID_LSB = DATA_W - FID_W;

  always_comb begin
    rd_data = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (rd_port == PORT_W'(p)) begin
        case (rd_sel)
          SEL_MAP: begin
            rd_data[NUM_PORTS-1:0]      = mask_q[p];
            rd_data[FID_LSB +: FID_W]   = fid_q[p];
          end
          SEL_VID:  rd_data[VID_W-1:0]   = vid_q[p];
          SEL_CTRL: rd_data[STATE_W-1:0] = state_q[p];
          default:  rd_data = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/vlan_egress_lookup.sv
module vlan_egress_lookup
  import vlan_egress_pkg::*;
#(
  parameter int NUM_PORTS = 7,
  parameter int FID_W     = 4,
  parameter int PORT_W    = 3
) (
  input  logic [PORT_W-1:0]                   in_port,
  input  logic [NUM_PORTS-1:0][NUM_PORTS-1:0] mask_q,
  input  logic [NUM_PORTS-1:0][FID_W-1:0]     fid_q,
  input  logic [NUM_PORTS-1:0][STATE_W-1:0]   state_q,
  output logic [NUM_PORTS-1:0]                out_mask,
  output logic [FID_W-1:0]                    out_fid
);

  logic [NUM_PORTS-1:0] fwd_set;
  logic [NUM_PORTS-1:0] sel_mask;
  logic                 sel_fwd;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_fwd
    assign fwd_set[p] = (state_q[p] == ST_FWD);
  end

  always_comb begin
    sel_mask = '0;
    sel_fwd  = 1'b0;
    out_fid  = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (in_port == PORT_W'(p)) begin
        sel_mask = mask_q[p];
        sel_fwd  = fwd_set[p];
        out_fid  = fid_q[p];
      end
    end
    out_mask = sel_fwd ? (sel_mask & fwd_set) : '0;
  end

endmodule

// File: rtl/vlan_resp_stage.sv
module vlan_resp_stage #(
  parameter int NUM_PORTS = 7,
  parameter int FID_W     = 4,
  parameter int PORT_W    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [PORT_W-1:0]    in_port,
  input  logic [NUM_PORTS-1:0] in_mask,
  input  logic [FID_W-1:0]     in_fid,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [PORT_W-1:0]    out_port,
  output logic [NUM_PORTS-1:0] out_mask,
  output logic [FID_W-1:0]     out_fid
);

  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_port  <= '0;
      out_mask  <= '0;
      out_fid   <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_port  <= in_port;
      out_mask  <= in_mask;
      out_fid   <= in_fid;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/vlan_egress_filter.sv
module vlan_egress_filter
  import vlan_egress_pkg::*;
#(
  parameter int NUM_PORTS = 7,
  parameter int FID_W     = 4,
  parameter int VID_W     = 12,
  parameter int DATA_W    = 16,
  parameter logic [NUM_PORTS-1:0] GROUP_A = 7'h4F,
  parameter logic [FID_W-1:0]     FID_A   = 4'd1,
  parameter logic [FID_W-1:0]     FID_B   = 4'd2,
  localparam int PORT_W = $clog2(NUM_PORTS + 1),
  localparam int ADDR_W = PORT_W + SEL_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [DATA_W-1:0]    cfg_wdata,
  output logic [DATA_W-1:0]    cfg_rdata,
  input  logic                 lkp_valid,
  output logic                 lkp_ready,
  input  logic [PORT_W-1:0]    lkp_port,
  output logic                 egr_valid,
  input  logic                 egr_ready,
  output logic [PORT_W-1:0]    egr_port,
  output logic [NUM_PORTS-1:0] egr_mask,
  output logic [FID_W-1:0]     egr_fid
);

  logic [NUM_PORTS-1:0][NUM_PORTS-1:0] mask_q;
  logic [NUM_PORTS-1:0][FID_W-1:0]     fid_q;
  logic [NUM_PORTS-1:0][VID_W-1:0]     vid_q;
  logic [NUM_PORTS-1:0][STATE_W-1:0]   state_q;
  logic [PORT_W-1:0]                   cfg_port;
  vef_sel_e                            cfg_sel;
  logic [NUM_PORTS-1:0]                lk_mask;
  logic [FID_W-1:0]                    lk_fid;

  assign cfg_port = cfg_addr[ADDR_W-1:SEL_W];
  assign cfg_sel  = vef_sel_e'(cfg_addr[SEL_W-1:0]);

  vlan_cfg_regs #(
    .NUM_PORTS(NUM_PORTS), .FID_W(FID_W), .VID_W(VID_W), .DATA_W(DATA_W),
    .PORT_W(PORT_W), .GROUP_A(GROUP_A), .FID_A(FID_A), .FID_B(FID_B)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_port(cfg_port),
    .wr_sel(cfg_sel), .wr_data(cfg_wdata), .mask_q(mask_q), .fid_q(fid_q),
    .vid_q(vid_q), .state_q(state_q)
  );

  vlan_cfg_readmux #(
    .NUM_PORTS(NUM_PORTS), .FID_W(FID_W), .VID_W(VID_W), .DATA_W(DATA_W),
    .PORT_W(PORT_W)
  ) u_rmux (
    .rd_port(cfg_port), .rd_sel(cfg_sel), .mask_q(mask_q), .fid_q(fid_q),
    .vid_q(vid_q), .state_q(state_q), .rd_data(cfg_rdata)
  );

  vlan_egress_lookup #(
    .NUM_PORTS(NUM_PORTS), .FID_W(FID_W), .PORT_W(PORT_W)
  ) u_lkp (
    .in_port(lkp_port), .mask_q(mask_q), .fid_q(fid_q), .state_q(state_q),
    .out_mask(lk_mask), .out_fid(lk_fid)
  );

  vlan_resp_stage #(
    .NUM_PORTS(NUM_PORTS), .FID_W(FID_W), .PORT_W(PORT_W)
  ) u_resp (
    .clk(clk), .rst_n(rst_n), .in_valid(lkp_valid), .in_ready(lkp_ready),
    .in_port(lkp_port), .in_mask(lk_mask), .in_fid(lk_fid),
    .out_valid(egr_valid), .out_ready(egr_ready), .out_port(egr_port),
    .out_mask(egr_mask), .out_fid(egr_fid)
  );

endmodule

// File: rtl/vlan_egress_filter_chk.sv
module vlan_egress_filter_chk #(
  parameter int NUM_PORTS = 7,
  parameter int FID_W     = 4,
  parameter int VID_W     = 12,
  parameter int DATA_W    = 16,
  parameter int PORT_W    = 3,
  parameter int ADDR_W    = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    cfg_addr,
  input logic [DATA_W-1:0]    cfg_rdata,
  input logic                 lkp_valid,
  input logic                 lkp_ready,
  input logic [PORT_W-1:0]    lkp_port,
  input logic                 egr_valid,
  input logic                 egr_ready,
  input logic [PORT_W-1:0]    egr_port,
  input logic [NUM_PORTS-1:0] egr_mask,
  input logic [FID_W-1:0]     egr_fid
);

  localparam int FID_LSB = DATA_W - FID_W;

  assert_map_gap_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr[1:0] == 2'd0) |-> (cfg_rdata[FID_LSB-1:NUM_PORTS] == '0));

  assert_no_self_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (egr_valid && int'(egr_port) < NUM_PORTS) |-> !egr_mask[egr_port]);

  assert_vid_top_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr[1:0] == 2'd1) |-> (cfg_rdata[DATA_W-1:VID_W] == '0));

  assert_ctrl_top_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr[1:0] == 2'd2) |-> (cfg_rdata[DATA_W-1:2] == '0));

  assert_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_valid && lkp_ready) |=> (egr_valid && egr_port == $past(lkp_port)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (egr_valid && !egr_ready) |=>
      (egr_valid && $stable(egr_port) && $stable(egr_mask) && $stable(egr_fid)));

  assert_stall_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (egr_valid && !egr_ready) |-> !lkp_ready);

  assert_bad_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (egr_valid && int'(egr_port) >= NUM_PORTS) |-> (egr_mask == '0 && egr_fid == '0));

endmodule

bind vlan_egress_filter vlan_egress_filter_chk #(
  .NUM_PORTS(NUM_PORTS), .FID_W(FID_W), .VID_W(VID_W), .DATA_W(DATA_W),
  .PORT_W(PORT_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
  .lkp_valid(lkp_valid), .lkp_ready(lkp_ready), .lkp_port(lkp_port),
  .egr_valid(egr_valid), .egr_ready(egr_ready), .egr_port(egr_port),
  .egr_mask(egr_mask), .egr_fid(egr_fid)
);

// File: tb/sim_vlan_egress_filter.sv
`timescale 1ns/1ps
module sim_vlan_egress_filter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        lkp_valid = 1'b0;
  logic        lkp_ready;
  logic [2:0]  lkp_port = '0;
  logic        egr_valid;
  logic        egr_ready = 1'b1;
  logic [2:0]  egr_port;
  logic [6:0]  egr_mask;
  logic [3:0]  egr_fid;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vlan_egress_filter u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lkp_valid(lkp_valid),
    .lkp_ready(lkp_ready), .lkp_port(lkp_port), .egr_valid(egr_valid),
    .egr_ready(egr_ready), .egr_port(egr_port), .egr_mask(egr_mask),
    .egr_fid(egr_fid)
  );

  // {ingress port, expected mask, expected FID} after reset
  localparam logic [13:0] RST_TAB [0:6] = '{
    {3'd0, 7'h4E, 4'd1}, {3'd1, 7'h4D, 4'd1}, {3'd2, 7'h4B, 4'd1},
    {3'd3, 7'h47, 4'd1}, {3'd4, 7'h20, 4'd2}, {3'd5, 7'h10, 4'd2},
    {3'd6, 7'h0F, 4'd1}
  };

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] port, input logic [1:0] sel,
                           input logic [15:0] data);
    @(negedge clk);
    cfg_addr = {port, sel}; cfg_wdata = data; cfg_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [2:0] port, input logic [1:0] sel,
                          output logic [15:0] data);
    @(negedge clk);
    cfg_addr = {port, sel};
    #1 data = cfg_rdata;
  endtask

  task automatic lookup(input logic [2:0] port, input string req,
                        input logic [6:0] exp_mask, input logic [3:0] exp_fid);
    @(negedge clk);
    lkp_valid = 1'b1; lkp_port = port; egr_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    lkp_valid = 1'b0;
    check(req, "resp valid", 16'(egr_valid), 16'd1);
    check(req, "resp port", 16'(egr_port), 16'(port));
    check(req, "resp mask", 16'(egr_mask), 16'(exp_mask));
    check(req, "resp fid", 16'(egr_fid), 16'(exp_fid));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] rd;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 / R7: reset state at the ports
    @(negedge clk);
    check("R7", "ready after reset", 16'(lkp_ready), 16'd1);
    check("R7", "no response after reset", 16'(egr_valid), 16'd0);

    // R1 / R6: table walk of the reset groups
    for (int i = 0; i < 7; i++) begin
      logic [13:0] e;
      e = RST_TAB[i];
      lookup(e[13:11], "R1", e[10:4], e[3:0]);
      cfg_read(e[13:11], 2'd0, rd);
      check("R1", "map word", rd, {e[3:0], 5'd0, e[10:4]});
      cfg_read(e[13:11], 2'd1, rd);
      check("R1", "default vid", rd, 16'(e[13:11]) + 16'd1);
      cfg_read(e[13:11], 2'd2, rd);
      check("R1", "state forwarding", rd, 16'd3);
    end

    // R2 / R3: all-ones map write
    cfg_write(3'd2, 2'd0, 16'hFFFF);
    cfg_read(3'd2, 2'd0, rd);
    check("R2", "map gap bits zero", rd, 16'hF07B);
    check("R3", "own bit cleared", 16'(rd[2]), 16'd0);
    lookup(3'd2, "R6", 7'h7B, 4'hF);

    // R4: VID field width
    cfg_write(3'd3, 2'd1, 16'hFABC);
    cfg_read(3'd3, 2'd1, rd);
    check("R4", "vid stored", rd, 16'h0ABC);

    // R5 / R6: disable port 4
    cfg_write(3'd4, 2'd2, 16'h0000);
    cfg_read(3'd4, 2'd2, rd);
    check("R5", "state disabled", rd, 16'd0);
    lookup(3'd2, "R6", 7'h6B, 4'hF);
    lookup(3'd4, "R6", 7'h00, 4'd2);

    // R5: state 1 does not forward; upper bits dropped
    cfg_write(3'd4, 2'd2, 16'hFFF1);
    cfg_read(3'd4, 2'd2, rd);
    check("R5", "state low bits only", rd, 16'd1);
    lookup(3'd2, "R5", 7'h6B, 4'hF);
    cfg_write(3'd4, 2'd2, 16'd3);
    lookup(3'd2, "R6", 7'h7B, 4'hF);

    // R9: nonexistent port and unused word
    lookup(3'd7, "R9", 7'h00, 4'd0);
    cfg_write(3'd7, 2'd0, 16'hFFFF);
    cfg_read(3'd7, 2'd0, rd);
    check("R9", "port 7 reads zero", rd, 16'd0);
    cfg_write(3'd1, 2'd3, 16'hFFFF);
    cfg_read(3'd1, 2'd3, rd);
    check("R9", "word 3 reads zero", rd, 16'd0);
    cfg_read(3'd1, 2'd0, rd);
    check("R9", "port 1 map untouched", rd, 16'h104D);

    // R8: stall, then release together with a new request
    @(negedge clk);
    egr_ready = 1'b0; lkp_valid = 1'b1; lkp_port = 3'd0;
    @(posedge clk);
    @(negedge clk);
    lkp_port = 3'd1;
    for (int k = 0; k < 3; k++) begin
      check("R8", "ready low in stall", 16'(lkp_ready), 16'd0);
      check("R8", "held port", 16'(egr_port), 16'd0);
      check("R8", "held mask", 16'(egr_mask), 16'h4E);
      @(negedge clk);
    end
    egr_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    lkp_valid = 1'b0;
    check("R8", "next port", 16'(egr_port), 16'd1);
    check("R8", "next mask", 16'(egr_mask), 16'h4D);

    // R10: write and lookup on the same edge
    @(negedge clk);
    cfg_addr = {3'd0, 2'd0}; cfg_wdata = 16'h5002; cfg_we = 1'b1;
    lkp_valid = 1'b1; lkp_port = 3'd0;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0; lkp_valid = 1'b0;
    check("R10", "old mask", 16'(egr_mask), 16'h4E);
    check("R10", "old fid", 16'(egr_fid), 16'd1);
    lookup(3'd0, "R10", 7'h02, 4'd5);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule